// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block walks an external display driver chip through its switch-on, switch-off and standby procedures. Each procedure is a fixed series of register writes, sent one at a time to a separate register-write engine over a request/ready port. Timed pauses sit between some of the steps. Software or a power manager raises a one-cycle command. The sequencer then runs the whole procedure by itself and raises `busy` until the last write has been accepted.

Switch-on takes one of two routes, depending on whether the driver's supply is already up. If the supply is down, the block asks an external initialisation block for a full bring-up. If the supply is up, it rewrites three registers to restore them. Both routes then share a common tail. In that tail the display control register climbs a fixed ladder of values, and the polarity bit is merged into every rung. The tail ends by selecting the panel's RAM data port and raising `disp_on`. Switch-off lowers `disp_on` first and then steps the ladder back down. Standby runs switch-off when needed, marks the supply as down, and then places the driver in its low-power state.

Top module: `panel_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `disp_on`, `powered`, `wr_req` and `init_req` are all 0.
- R2: Switch-on with `powered`=0 first raises `init_req` and holds it until `init_ack` is seen. At that handshake `powered` becomes 1, and the common tail (R4) follows.
- R3: Switch-on with `powered`=1 writes register 0x12=0x0013, then 0x0B=0x4400, then 0x13=0x3119, and then runs the common tail (R4). It makes no full-initialisation request.
- R4: The common tail writes 0x10=0x4740, then a long wait, then 0x07=0x0041|P, then a short wait, then 0x07=0x0061|P and 0x07=0x0063|P with no wait between them, then a short wait, then 0x07=0x0073|P. After that it sends one index-only message with `wr_addr_only`=1, register 0x22 and value 0. `disp_on` rises on the cycle after that message is accepted. P is 0x0004 when `invert`=0 and 0x0000 when `invert`=1. `invert` is sampled in the cycle the command is accepted.
- R5: Switch-off clears `disp_on` on the edge that accepts the command. It then writes 0x0B=0x4000, 0x07=0x0072|P, a long wait, 0x07=0x0062|P, a long wait, and then 0x07=0x0000, 0x10=0x0000, 0x12=0x0003 and 0x13=0x1119.
- R6: Standby clears `powered` on acceptance. If the display was on, standby first runs the full R5 sequence. In every case it ends with the write 0x10=0x0001.
- R7: A switch-on while `disp_on`=1, a switch-off while `disp_on`=0, and any command while `busy`=1 are ignored: no write is issued and the state is unchanged. When several commands arrive together, standby wins over switch-off, which wins over switch-on.
- R8: Between the accepted writes on either side of a long wait, at least `WAIT_LONG` clock cycles pass. For a short wait, at least `WAIT_SHORT` clock cycles pass.
- R9: While `wr_req`=1 and `wr_rdy`=0, `wr_req`, `wr_reg` and `wr_val` hold their values. Each cycle with `wr_req` and `wr_rdy` both high transfers exactly one message.
- R10: `busy` is 1 from the edge that accepts a command. It falls on the first edge after the edge that accepts the final message. While `busy`=0, no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_on | input | 1 | One-cycle switch-on command |
| cmd_off | input | 1 | One-cycle switch-off command |
| cmd_standby | input | 1 | One-cycle standby command |
| invert | input | 1 | 1 selects inverted polarity (P=0x0000) |
| wr_req | output | 1 | Register-write request to the write engine |
| wr_reg | output | 8 | Driver register index |
| wr_val | output | 16 | Register value (0 for index-only messages) |
| wr_addr_only | output | 1 | 1 marks an index-only message |
| wr_rdy | input | 1 | Write engine accepts the current message |
| init_req | output | 1 | Full-initialisation request to the external block |
| init_ack | input | 1 | Full initialisation complete |
| disp_on | output | 1 | Display visible |
| powered | output | 1 | Driver supply considered up |
| busy | output | 1 | A procedure is in progress |

## Verification
Each command is accepted on the first rising edge that sees it, so `busy` and the cleared `disp_on` can be checked half a cycle after that edge. The bench logs every handshake at the falling edge just before the rising edge that completes it, tagging it with that edge's number. With the number of that final edge in hand, `busy` must read low exactly one edge later. A long wait adds `WAIT_LONG`+3 edges between the neighbouring handshakes, and a short wait adds `WAIT_SHORT`+3 edges. The checks bound these gaps from below so they still hold when the write engine stalls, and ignored commands are observed over eight cycles after the pulse.

// File: rtl/panel_seq_pkg.sv
// Shared widths, step encoding and program entry points for the panel
// power sequencer. Assumes the driver uses 8-bit indices, 16-bit values.
package panel_seq_pkg;
    parameter int REG_W = 8;
    parameter int VAL_W = 16;
    parameter int PC_W  = 5;

    typedef enum logic [2:0] {
        K_END,      // procedure finished
        K_WRITE,    // full register write
        K_INDEX,    // index-only message
        K_WAIT_L,   // long pause
        K_WAIT_S,   // short pause
        K_PWRCHK,   // branch on supply state / request bring-up
        K_SETON,    // raise display-on and finish
        K_BRSTBY    // continue into standby tail or finish
    } step_kind_e;

    typedef struct packed {
        step_kind_e        kind;
        logic [REG_W-1:0]  idx;
        logic [VAL_W-1:0]  val;
    } step_t;

    localparam logic [PC_W-1:0] PC_ON   = PC_W'(0);
    localparam logic [PC_W-1:0] PC_TAIL = PC_W'(4);
    localparam logic [PC_W-1:0] PC_OFF  = PC_W'(16);
    localparam logic [PC_W-1:0] PC_STBY = PC_W'(28);
endpackage

// File: rtl/panel_seq_table.sv
// Step program: maps a program counter to the step to perform.
// Purely combinational; the polarity bit is merged into the control-ladder
// values here. Assumes pc addresses only the entries listed.
module panel_seq_table
    import panel_seq_pkg::*;
(
    input  logic [PC_W-1:0] pc,
    input  logic            inv,
    output step_t           st
);
    localparam int POL_NORMAL = 'h0004;

    function automatic step_t mk(step_kind_e k, int i, int v);
        step_t s;
        s.kind = k;
        s.idx  = REG_W'(i);
        s.val  = VAL_W'(v);
        return s;
    endfunction

    int pol;

    // Decode the step at the current program counter.
    always_comb begin
        pol = inv ? 0 : POL_NORMAL;
        case (int'(pc))
            0:  st = mk(K_PWRCHK, 0, 0);
            1:  st = mk(K_WRITE, 'h12, 'h0013);
            2:  st = mk(K_WRITE, 'h0B, 'h4400);
            3:  st = mk(K_WRITE, 'h13, 'h3119);
            4:  st = mk(K_WRITE, 'h10, 'h4740);
            5:  st = mk(K_WAIT_L, 0, 0);
            6:  st = mk(K_WRITE, 'h07, 'h0041 | pol);
            7:  st = mk(K_WAIT_S, 0, 0);
            8:  st = mk(K_WRITE, 'h07, 'h0061 | pol);
            9:  st = mk(K_WRITE, 'h07, 'h0063 | pol);
            10: st = mk(K_WAIT_S, 0, 0);
            11: st = mk(K_WRITE, 'h07, 'h0073 | pol);
            12: st = mk(K_INDEX, 'h22, 0);
            13: st = mk(K_SETON, 0, 0);
            16: st = mk(K_WRITE, 'h0B, 'h4000);
            17: st = mk(K_WRITE, 'h07, 'h0072 | pol);
            18: st = mk(K_WAIT_L, 0, 0);
            19: st = mk(K_WRITE, 'h07, 'h0062 | pol);
            20: st = mk(K_WAIT_L, 0, 0);
            21: st = mk(K_WRITE, 'h07, 'h0000);
            22: st = mk(K_WRITE, 'h10, 'h0000);
            23: st = mk(K_WRITE, 'h12, 'h0003);
            24: st = mk(K_WRITE, 'h13, 'h1119);
            25: st = mk(K_BRSTBY, 0, 0);
            28: st = mk(K_WRITE, 'h10, 'h0001);
            default: st = mk(K_END, 0, 0);
        endcase
    end
endmodule

// File: rtl/panel_seq_timer.sv
// Down-counting pause timer. A start pulse loads len-1; done is high in
// the cycle the count reaches zero. Assumes len >= 1 and that start is not
// raised while a pause is running.
module panel_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= len - CNT_W'(1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = run_q && (cnt_q == '0);
endmodule

// File: rtl/panel_seq_cmd.sv
// Command filter: decides whether an incoming command starts a procedure
// and where in the program it starts. Standby beats switch-off, which
// beats switch-on. Redundant commands and anything arriving while busy
// are dropped.
module panel_seq_cmd
    import panel_seq_pkg::*;
(
    input  logic            busy,
    input  logic            disp_on,
    input  logic            cmd_on,
    input  logic            cmd_off,
    input  logic            cmd_standby,
    output logic            accept,
    output logic            acc_on,
    output logic            acc_stby,
    output logic [PC_W-1:0] acc_pc
);
    logic take_off, take_on;

    // Pick the winning effective command and its entry point.
    always_comb begin
        take_off = cmd_off && disp_on;
        take_on  = cmd_on && !disp_on;
        accept   = !busy && (cmd_standby || take_off || take_on);
        acc_stby = cmd_standby;
        acc_on   = !cmd_standby && !take_off && take_on;
        if (cmd_standby)   acc_pc = disp_on ? PC_OFF : PC_STBY;
        else if (take_off) acc_pc = PC_OFF;
        else               acc_pc = PC_ON;
    end
endmodule

// File: rtl/panel_seq.sv
// Display panel power sequencer top level. Steps through the program held
// in panel_seq_table, one step at a time: writes wait for the write engine,
// pauses wait for the timer, the supply check waits for the external
// bring-up. Assumes one-cycle command pulses and a write engine that may
// stall wr_rdy for any number of cycles.
module panel_seq
    import panel_seq_pkg::*;
#(
    parameter int WAIT_LONG  = 10_000_000,
    parameter int WAIT_SHORT = 8_250_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_on,
    input  logic             cmd_off,
    input  logic             cmd_standby,
    input  logic             invert,
    output logic             wr_req,
    output logic [REG_W-1:0] wr_reg,
    output logic [VAL_W-1:0] wr_val,
    output logic             wr_addr_only,
    input  logic             wr_rdy,
    output logic             init_req,
    input  logic             init_ack,
    output logic             disp_on,
    output logic             powered,
    output logic             busy
);
    localparam int WAIT_MAX = (WAIT_LONG > WAIT_SHORT) ? WAIT_LONG : WAIT_SHORT;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);

    logic             busy_q, issued_q, stby_q, inv_q, on_q, pwr_q;
    logic [PC_W-1:0]  pc_q;
    logic             wr_req_q, wr_ao_q, init_req_q;
    logic [REG_W-1:0] wr_reg_q;
    logic [VAL_W-1:0] wr_val_q;

    step_t            st;
    logic             accept, acc_on, acc_stby;
    logic [PC_W-1:0]  acc_pc;
    logic             tmr_start, tmr_done;
    logic [CNT_W-1:0] tmr_len;

    panel_seq_cmd u_cmd (
        .busy        (busy_q),
        .disp_on     (on_q),
        .cmd_on      (cmd_on),
        .cmd_off     (cmd_off),
        .cmd_standby (cmd_standby),
        .accept      (accept),
        .acc_on      (acc_on),
        .acc_stby    (acc_stby),
        .acc_pc      (acc_pc)
    );

    panel_seq_table u_tab (
        .pc  (pc_q),
        .inv (inv_q),
        .st  (st)
    );

    panel_seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (tmr_len),
        .done  (tmr_done)
    );

    // Start a pause on the first cycle of a wait step.
    always_comb begin
        tmr_start = busy_q && !issued_q &&
                    (st.kind == K_WAIT_L || st.kind == K_WAIT_S);
        tmr_len   = (st.kind == K_WAIT_L) ? CNT_W'(WAIT_LONG) : CNT_W'(WAIT_SHORT);
    end

    // Main sequencer: accept a command, then execute one step at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            issued_q   <= 1'b0;
            stby_q     <= 1'b0;
            inv_q      <= 1'b0;
            on_q       <= 1'b0;
            pwr_q      <= 1'b0;
            pc_q       <= '0;
            wr_req_q   <= 1'b0;
            wr_ao_q    <= 1'b0;
            wr_reg_q   <= '0;
            wr_val_q   <= '0;
            init_req_q <= 1'b0;
        end else if (!busy_q) begin
            if (accept) begin
                busy_q   <= 1'b1;
                issued_q <= 1'b0;
                pc_q     <= acc_pc;
                inv_q    <= invert;
                stby_q   <= acc_stby;
                if (!acc_on)  on_q  <= 1'b0;
                if (acc_stby) pwr_q <= 1'b0;
            end
        end else begin
            case (st.kind)
                K_WRITE, K_INDEX: begin
                    if (!issued_q) begin
                        issued_q <= 1'b1;
                        wr_req_q <= 1'b1;
                        wr_reg_q <= st.idx;
                        wr_val_q <= st.val;
                        wr_ao_q  <= (st.kind == K_INDEX);
                    end else if (wr_rdy) begin
                        issued_q <= 1'b0;
                        wr_req_q <= 1'b0;
                        wr_ao_q  <= 1'b0;
                        pc_q     <= pc_q + PC_W'(1);
                    end
                end
                K_WAIT_L, K_WAIT_S: begin
                    if (!issued_q) begin
                        issued_q <= 1'b1;
                    end else if (tmr_done) begin
                        issued_q <= 1'b0;
                        pc_q     <= pc_q + PC_W'(1);
                    end
                end
                K_PWRCHK: begin
                    if (pwr_q && !issued_q) begin
                        pc_q <= pc_q + PC_W'(1);
                    end else if (!issued_q) begin
                        issued_q   <= 1'b1;
                        init_req_q <= 1'b1;
                    end else if (init_ack) begin
                        issued_q   <= 1'b0;
                        init_req_q <= 1'b0;
                        pwr_q      <= 1'b1;
                        pc_q       <= PC_TAIL;
                    end
                end
                K_SETON: begin
                    on_q   <= 1'b1;
                    busy_q <= 1'b0;
                end
                K_BRSTBY: begin
                    if (stby_q) pc_q   <= PC_STBY;
                    else        busy_q <= 1'b0;
                end
                default: busy_q <= 1'b0;
            endcase
        end
    end

    assign wr_req       = wr_req_q;
    assign wr_reg       = wr_reg_q;
    assign wr_val       = wr_val_q;
    assign wr_addr_only = wr_ao_q;
    assign init_req     = init_req_q;
    assign disp_on      = on_q;
    assign powered      = pwr_q;
    assign busy         = busy_q;
endmodule

// File: rtl/panel_seq_chk.sv
// Protocol and state checker for panel_seq, attached by bind.
module panel_seq_chk
    import panel_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_on,
    input logic             cmd_off,
    input logic             cmd_standby,
    input logic             wr_req,
    input logic             wr_rdy,
    input logic [REG_W-1:0] wr_reg,
    input logic [VAL_W-1:0] wr_val,
    input logic             init_req,
    input logic             init_ack,
    input logic             disp_on,
    input logic             powered,
    input logic             busy
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_rdy |=> wr_req && $stable(wr_reg) && $stable(wr_val)); // R9
    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        init_req && !init_ack |=> init_req); // R2
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && (cmd_off || cmd_standby) |=> !disp_on); // R5
    AST_STBY_UNPOWER: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_standby |=> !powered); // R6
    AST_ON_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && disp_on && cmd_on && !cmd_off && !cmd_standby |=> !busy); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_req && !init_req); // R10
    AST_ON_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        disp_on |-> powered); // R2
endmodule

bind panel_seq panel_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_on      (cmd_on),
    .cmd_off     (cmd_off),
    .cmd_standby (cmd_standby),
    .wr_req      (wr_req),
    .wr_rdy      (wr_rdy),
    .wr_reg      (wr_reg),
    .wr_val      (wr_val),
    .init_req    (init_req),
    .init_ack    (init_ack),
    .disp_on     (disp_on),
    .powered     (powered),
    .busy        (busy)
);

// File: tb/panel_seq_test.sv
`timescale 1ns/1ps
module panel_seq_test;
    localparam int WL = 20;
    localparam int WS = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_on = 1'b0, cmd_off = 1'b0, cmd_standby = 1'b0, invert = 1'b0;
    logic wr_req, wr_addr_only, init_req, disp_on, powered, busy;
    logic [7:0]  wr_reg;
    logic [15:0] wr_val;
    logic wr_rdy = 1'b1;
    logic init_ack = 1'b0;

    panel_seq #(.WAIT_LONG(WL), .WAIT_SHORT(WS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .cmd_off(cmd_off),
        .cmd_standby(cmd_standby), .invert(invert), .wr_req(wr_req),
        .wr_reg(wr_reg), .wr_val(wr_val), .wr_addr_only(wr_addr_only),
        .wr_rdy(wr_rdy), .init_req(init_req), .init_ack(init_ack),
        .disp_on(disp_on), .powered(powered), .busy(busy)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int stall = 0;
    int init_cnt = 0;
    logic [25:0] logq [0:63];
    int          logc [0:63];
    int          nlog = 0;
    logic [25:0] expq [0:63];
    int          nexp = 0;
    logic mdl_on = 1'b0, mdl_pwr = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Drive ready / bring-up ack, then log the handshakes due at the next edge.
    always @(negedge clk) begin
        wr_rdy = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) == 0);
        if (init_req && !init_ack) init_cnt = init_cnt + 1; else init_cnt = 0;
        init_ack = init_req && (init_cnt >= 3);
        if (rst_n && nlog < 64) begin
            if (wr_req && wr_rdy) begin
                logq[nlog] = {wr_addr_only ? 2'd2 : 2'd1, wr_reg, wr_val};
                logc[nlog] = cyc + 1;
                nlog = nlog + 1;
            end else if (init_req && init_ack) begin
                logq[nlog] = {2'd3, 8'h00, 16'h0000};
                logc[nlog] = cyc + 1;
                nlog = nlog + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic ew(input int i, input int v);
        expq[nexp] = {2'd1, 8'(i), 16'(v)};
        nexp++;
    endtask

    task automatic build_on(input logic pw, input logic iv);
        int p = iv ? 0 : 4;
        if (!pw) begin expq[nexp] = {2'd3, 24'h0}; nexp++; end
        else begin ew('h12, 'h0013); ew('h0B, 'h4400); ew('h13, 'h3119); end
        ew('h10, 'h4740); ew('h07, 'h41 | p); ew('h07, 'h61 | p);
        ew('h07, 'h63 | p); ew('h07, 'h73 | p);
        expq[nexp] = {2'd2, 8'h22, 16'h0}; nexp++;
    endtask

    task automatic build_off(input logic iv);
        int p = iv ? 0 : 4;
        ew('h0B, 'h4000); ew('h07, 'h72 | p); ew('h07, 'h62 | p);
        ew('h07, 0); ew('h10, 0); ew('h12, 3); ew('h13, 'h1119);
    endtask

    task automatic gap(input int a, input int b, input int mn, input string rq);
        chk(logc[b] - logc[a] >= mn, rq, logc[b] - logc[a], mn);
    endtask

    task automatic compare(input string rq);
        chk(nlog == nexp, rq, nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++)
            chk(logq[i] == expq[i], rq, logq[i], expq[i]);
    endtask

    // which: 0 on, 1 off, 2 standby. poke: fire a standby while busy.
    task automatic run(input int which, input logic iv, input bit poke, input string rq);
        int t = 0;
        nlog = 0;
        @(negedge clk);
        invert = iv;
        cmd_on = (which == 0); cmd_off = (which == 1); cmd_standby = (which == 2);
        @(negedge clk);
        cmd_on = 0; cmd_off = 0; cmd_standby = 0;
        invert = ~iv;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        if (which != 0) chk(disp_on == 1'b0, "R5 display-on cleared first", disp_on, 0);
        if (which == 2) chk(powered == 1'b0, "R6 powered cleared", powered, 0);
        if (poke) begin
            repeat (2) @(negedge clk);
            cmd_standby = 1;
            @(negedge clk);
            cmd_standby = 0;
        end
        while (busy && t < 20000) begin @(negedge clk); t++; end
        chk(nlog > 0 && (cyc - logc[nlog > 0 ? nlog - 1 : 0]) == 1,
            "R10 busy falls one edge after final handshake",
            cyc - logc[nlog > 0 ? nlog - 1 : 0], 1);
        invert = iv;
    endtask

    task automatic ignored(input int which, input string rq);
        logic on0 = disp_on;
        logic pw0 = powered;
        int hits = 0;
        nlog = 0;
        @(negedge clk);
        cmd_on = (which == 0); cmd_off = (which == 1);
        @(negedge clk);
        cmd_on = 0; cmd_off = 0;
        for (int k = 0; k < 8; k++) begin
            if (busy) hits++;
            @(negedge clk);
        end
        chk(hits == 0, rq, hits, 0);
        chk(nlog == 0, rq, nlog, 0);
        chk(disp_on == on0 && powered == pw0, rq, {disp_on, powered}, {on0, pw0});
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, disp_on, powered, wr_req, init_req} == 5'b0, "R1 reset state",
            {busy, disp_on, powered, wr_req, init_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, disp_on, powered, wr_req, init_req} == 5'b0, "R1 after release",
            {busy, disp_on, powered, wr_req, init_req}, 0);

        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 2; v++) begin
                logic iv = v[0];
                stall = s;
                // Standby from whatever state: R6
                nexp = 0;
                if (mdl_on) build_off(iv);
                ew('h10, 'h0001);
                run(2, iv, 0, "R6");
                compare("R6 standby sequence");
                if (mdl_on) begin gap(1, 2, WL, "R8 standby long wait"); gap(2, 3, WL, "R8 standby long wait"); end
                mdl_on = 0; mdl_pwr = 0;
                chk(!disp_on && !powered, "R6 final state", {disp_on, powered}, 0);

                // Switch-on without supply: R2, R4, poke while busy R7
                nexp = 0; build_on(0, iv);
                run(0, iv, 1, "R2");
                compare("R2 R4 full-init switch-on, R7 standby while busy ignored");
                gap(1, 2, WL, "R8 on long wait"); gap(2, 3, WS, "R8 on short wait");
                gap(4, 5, WS, "R8 on short wait");
                chk(disp_on && powered, "R2 display and power up", {disp_on, powered}, 3);
                mdl_on = 1; mdl_pwr = 1;

                ignored(0, "R7 switch-on while on ignored");

                // Switch-off: R5
                nexp = 0; build_off(~iv);
                run(1, ~iv, 0, "R5");
                compare("R5 switch-off sequence");
                gap(1, 2, WL, "R8 off long wait"); gap(2, 3, WL, "R8 off long wait");
                chk(!disp_on && powered, "R5 final state", {disp_on, powered}, 1);
                mdl_on = 0;

                ignored(1, "R7 switch-off while off ignored");

                // Switch-on with supply up: R3, R4
                nexp = 0; build_on(1, ~iv);
                run(0, ~iv, 0, "R3");
                compare("R3 R4 restore switch-on");
                gap(3, 4, WL, "R8 restore long wait"); gap(4, 5, WS, "R8 restore short wait");
                gap(6, 7, WS, "R8 restore short wait");
                chk(disp_on, "R4 display-on raised", disp_on, 1);
                mdl_on = 1;
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule